// File: doc/BRIEF.md
# Right-Hand Wall-Following Controller

This block is the steering controller of a small maze-solving robot. It reads two antenna bits, one on the left and one on the right, each 1 while that antenna touches a wall. It drives three motion commands: step forward, turn left and turn right. After reset the robot is lost and moves straight ahead until an antenna touches something. It then rotates counter-clockwise until both antennae are clear. From that point it keeps the wall on its right by weaving: it turns slightly right while stepping until the right antenna touches, then turns slightly left while stepping until contact is lost. When the wall falls away at an outside corner, it keeps turning right until the right antenna finds the new surface.

Five states are named. LOST drives forward only. RCCW drives turn-left only. WALL1 drives turn-right plus forward. WALL2 drives turn-left plus forward. CORNER drives turn-right plus forward. The transitions are as follows. LOST moves to RCCW on any contact. RCCW moves to WALL1 when both antennae are clear. From WALL1, WALL2 or CORNER, any left contact leads to RCCW. WALL1 and CORNER move to WALL2 on right-only contact. WALL2 moves to CORNER when both antennae are clear. In every other case the state holds. CORNER has the same outputs and transitions as WALL1, so parameter `REDUCED` = 1 merges the two and keeps the state in 2 bits instead of 3. The motion commands are registered and are a pure function of the current state.

Top module: `ant_wall_follower`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, the outputs are forward=1, left=0, right=0 (state LOST).
- R2: In LOST with both antennae at 0, the outputs stay forward-only. Any antenna at 1 produces turn-left-only (RCCW) after the next rising clock edge.
- R3: RCCW (turn-left-only) holds while either antenna is 1. With both antennae at 0, the next edge gives turn-right plus forward (WALL1).
- R4: In any wall-following state (forward together with a turn), a left antenna at 1 leads to RCCW at the next edge, whatever the right antenna reads.
- R5: In a turn-right-plus-forward state (WALL1 or CORNER), right=1 with left=0 leads to turn-left plus forward (WALL2) at the next edge.
- R6: WALL2 holds while the right antenna is 1 and the left is 0.
- R7: WALL2 with both antennae at 0 moves to a turn-right-plus-forward state (CORNER, or WALL1 when reduced). That state holds while both antennae remain 0.
- R8: Turn-left and turn-right are never asserted together, and every output pattern is one of the four state patterns.
- R9: The 5-state and the 4-state variants give identical output sequences for any antenna sequence applied from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ant_l | input | 1 | Left antenna, 1 = touching a wall |
| ant_r | input | 1 | Right antenna, 1 = touching a wall |
| step_fwd | output | 1 | Step forward this cycle |
| turn_left | output | 1 | Turn left this cycle |
| turn_right | output | 1 | Turn right this cycle |

## Verification
The properties assume that the antenna bits are synchronous to `clk` and stable around the rising edge. Conditioning asynchronous sensors is left to the surrounding logic. The bench meets this by changing the antenna inputs only on the falling edge and reading the outputs shortly after the rising edge. Every antenna combination is legal in every state, so the random phase draws all four combinations freely. It compares both variants against a reference state model built from the transition list.

// File: rtl/ant_ctrl_pkg.sv
package ant_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_LOST   = 3'd0,
        ST_RCCW   = 3'd1,
        ST_WALL1  = 3'd2,
        ST_WALL2  = 3'd3,
        ST_CORNER = 3'd4
    } ant_state_e;

    typedef struct packed {
        logic fwd;
        logic left;
        logic right;
    } ant_drive_t;

    localparam int FULL_STATE_BITS    = 3;
    localparam int REDUCED_STATE_BITS = 2;

endpackage

// File: rtl/ant_next_state.sv
module ant_next_state
    import ant_ctrl_pkg::*;
#(
    parameter bit MERGE_CORNER = 1'b0
) (
    input  ant_state_e cur,
    input  logic       ant_l,
    input  logic       ant_r,
    output ant_state_e nxt
);

    localparam ant_state_e OPEN_STATE = MERGE_CORNER ? ST_WALL1 : ST_CORNER;

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_LOST:   nxt = (ant_l || ant_r) ? ST_RCCW : ST_LOST;
            ST_RCCW:   nxt = (ant_l || ant_r) ? ST_RCCW : ST_WALL1;
            ST_WALL1,
            ST_CORNER: begin
                if (ant_l)      nxt = ST_RCCW;
                else if (ant_r) nxt = ST_WALL2;
                else            nxt = cur;
            end
            ST_WALL2: begin
                if (ant_l)      nxt = ST_RCCW;
                else if (ant_r) nxt = ST_WALL2;
                else            nxt = OPEN_STATE;
            end
            default:   nxt = ST_LOST;
        endcase
    end

endmodule

// File: rtl/ant_drive_decode.sv
module ant_drive_decode
    import ant_ctrl_pkg::*;
(
    input  ant_state_e st,
    output ant_drive_t drv
);

    always_comb begin
        drv = '0;
        unique case (st)
            ST_LOST:   drv = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
            ST_RCCW:   drv = '{fwd: 1'b0, left: 1'b1, right: 1'b0};
            ST_WALL1,
            ST_CORNER: drv = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
            ST_WALL2:  drv = '{fwd: 1'b1, left: 1'b1, right: 1'b0};
            default:   drv = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
        endcase
    end

endmodule

// File: rtl/ant_wall_follower.sv
module ant_wall_follower
    import ant_ctrl_pkg::*;
#(
    parameter bit REDUCED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ant_l,
    input  logic ant_r,
    output logic step_fwd,
    output logic turn_left,
    output logic turn_right
);

    localparam int SW = REDUCED ? REDUCED_STATE_BITS : FULL_STATE_BITS;

    logic [SW-1:0] state_q;
    ant_state_e    cur_st;
    ant_state_e    nxt_st;
    ant_drive_t    nxt_drv;
    ant_drive_t    drv_q;

    generate
        if (REDUCED) begin : g_narrow
            assign cur_st = ant_state_e'({1'b0, state_q});
        end else begin : g_wide
            assign cur_st = ant_state_e'(state_q);
        end
    endgenerate

    ant_next_state #(.MERGE_CORNER(REDUCED)) u_next (
        .cur   (cur_st),
        .ant_l (ant_l),
        .ant_r (ant_r),
        .nxt   (nxt_st)
    );

    ant_drive_decode u_decode (
        .st  (nxt_st),
        .drv (nxt_drv)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW'(ST_LOST);
        else        state_q <= SW'(nxt_st);
    end

    // Registered Moore outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '{fwd: 1'b1, left: 1'b0, right: 1'b0};
        else        drv_q <= nxt_drv;
    end

    assign step_fwd   = drv_q.fwd;
    assign turn_left  = drv_q.left;
    assign turn_right = drv_q.right;

    // ---------------- assertions ----------------
    p_turn_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(turn_left && turn_right));

    p_pattern_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd || turn_left));

    p_lost_leave_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd && !turn_left && !turn_right && (ant_l || ant_r))
        |=> (turn_left && !step_fwd && !turn_right));

    p_rccw_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_left && !step_fwd && !ant_l && !ant_r)
        |=> (turn_right && step_fwd && !turn_left));

    p_follow_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd && (turn_left || turn_right) && ant_l)
        |=> (turn_left && !step_fwd));

    p_right_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd && turn_right && !ant_l && ant_r)
        |=> (step_fwd && turn_left && !turn_right));

    p_open_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd && (turn_left || turn_right) && !ant_l && !ant_r)
        |=> (step_fwd && turn_right && !turn_left));

    generate
        if (!REDUCED) begin : g_chk_wide
            p_state_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q <= SW'(ST_CORNER)));
        end
    endgenerate

endmodule

// File: tb/test_ant_wall_follower.sv
module test_ant_wall_follower;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ant_l = 1'b0;
    logic ant_r = 1'b0;
    logic f_a, tl_a, tr_a;
    logic f_b, tl_b, tr_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ant_wall_follower #(.REDUCED(1'b0)) i_ant_wall_follower (
        .clk(clk), .rst_n(rst_n), .ant_l(ant_l), .ant_r(ant_r),
        .step_fwd(f_a), .turn_left(tl_a), .turn_right(tr_a));

    ant_wall_follower #(.REDUCED(1'b1)) i_ant_wall_follower_red (
        .clk(clk), .rst_n(rst_n), .ant_l(ant_l), .ant_r(ant_r),
        .step_fwd(f_b), .turn_left(tl_b), .turn_right(tr_b));

    // expected output patterns {fwd,left,right}
    localparam logic [2:0] P_LOST = 3'b100;
    localparam logic [2:0] P_RCCW = 3'b010;
    localparam logic [2:0] P_RTF  = 3'b101;
    localparam logic [2:0] P_LTF  = 3'b110;

    task automatic chk(input string req, input logic [2:0] exp);
        n_checks++;
        if ({f_a, tl_a, tr_a} !== exp) begin
            n_fail++;
            $display("FAIL %s full variant: actual %b expected %b", req, {f_a, tl_a, tr_a}, exp);
        end
        n_checks++;
        if ({f_b, tl_b, tr_b} !== exp) begin
            n_fail++;
            $display("FAIL %s reduced variant: actual %b expected %b", req, {f_b, tl_b, tr_b}, exp);
        end
    endtask

    task automatic apply(input logic l, input logic r);
        @(negedge clk);
        ant_l = l;
        ant_r = r;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ant_l = 1'b0;
        ant_r = 1'b0;
        #40;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #25;
        chk("R1 during reset", P_LOST);
        do_reset();
        @(posedge clk); #2;
        chk("R1 after release", P_LOST);
    endtask

    task automatic t_lost();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            apply(1'b0, 1'b0);
            chk("R2 lost holds", P_LOST);
        end
        apply(1'b0, 1'b1);
        chk("R2 right contact", P_RCCW);
        do_reset();
        apply(1'b1, 1'b0);
        chk("R2 left contact", P_RCCW);
    endtask

    task automatic t_rccw();
        apply(1'b1, 1'b1);
        chk("R3 hold both", P_RCCW);
        apply(1'b0, 1'b1);
        chk("R3 hold right", P_RCCW);
        apply(1'b0, 1'b0);
        chk("R3 exit to wall1", P_RTF);
    endtask

    task automatic t_follow();
        apply(1'b0, 1'b0);
        chk("R7 wall1 holds open", P_RTF);
        apply(1'b0, 1'b1);
        chk("R5 wall1 to wall2", P_LTF);
        apply(1'b0, 1'b1);
        chk("R6 wall2 holds", P_LTF);
        apply(1'b0, 0);
        chk("R7 wall2 to corner", P_RTF);
        apply(1'b0, 1'b0);
        chk("R7 corner holds", P_RTF);
        apply(1'b0, 1'b1);
        chk("R5 corner to wall2", P_LTF);
        apply(1'b1, 1'b1);
        chk("R4 frontal from wall2", P_RCCW);
        apply(1'b0, 1'b0);
        chk("R3 exit again", P_RTF);
        apply(1'b1, 1'b0);
        chk("R4 left from wall1", P_RCCW);
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        chk("R4 left from corner", P_RCCW);
    endtask

    // reference model: 0 LOST,1 RCCW,2 WALL1,3 WALL2,4 CORNER
    function automatic int ref_next(input int s, input logic l, input logic r);
        case (s)
            0: return (l || r) ? 1 : 0;
            1: return (l || r) ? 1 : 2;
            2, 4: return l ? 1 : (r ? 3 : s);
            default: return l ? 1 : (r ? 3 : 4);
        endcase
    endfunction

    function automatic logic [2:0] ref_out(input int s);
        case (s)
            0: return P_LOST;
            1: return P_RCCW;
            3: return P_LTF;
            default: return P_RTF;
        endcase
    endfunction

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        int st = 0;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic l, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // bias toward no left contact so wall-following runs for a while
            l = (lfsr[3:0] == 4'd0);
            r = lfsr[7];
            apply(l, r);
            st = ref_next(st, l, r);
            chk("R9 random sequence", ref_out(st));
            n_checks++;
            if (tl_a && tr_a) begin
                n_fail++;
                $display("FAIL R8 both turns: actual 11 expected not 11");
            end
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lost();
        t_rccw();
        t_follow();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule